// File: doc/BRIEF.md
# Board Control Status Registers

A small register window for a development board. It exposes two identification constants (a build date code and the processor clock rate in hertz), an LED output register that software can set and read back, and a read-only view of the DIP switch inputs. Writing one exact key word to a dedicated write-only offset produces a single-cycle pulse that asks the board's reset controller to reset the system.

The bus is a simple synchronous one: an address inside a 64 KiB window, a write strobe with write data, and a read strobe whose data comes back one clock later from a register. The switch inputs are asynchronous to the bus clock and pass through a synchronizer chain before they can be read. The identification constants and the reset key are parameters set by the integrator.

Top module: `board_csr`

## Requirements
- R1: A read of offset 0x0 returns the parameter BUILD_CODE (default 0x09272011).
- R2: A read of offset 0x4 returns the parameter CLK_HZ (default 10000000, i.e. 0x00989680).
- R3: Offset 0x8 holds the LED register: a write stores bus_wdata[LED_W-1:0], led_out shows it from the cycle after the write (1 = lit), and a read returns it zero-extended to 32 bits.
- R4: A read of offset 0xC returns the switch inputs (1 = on) zero-extended; a switch change becomes readable by a read strobed two or more cycles after the change, through a two-stage synchronizer.
- R5: A write of exactly 0x0000DEAD to offset 0x10 drives sys_rst_req high for exactly the one cycle after the write.
- R6: A write to offset 0x10 of any other value, including one with non-zero upper 16 bits such as 0x0001DEAD, leaves sys_rst_req low.
- R7: A read of any offset in the window other than 0x0, 0x4, 0x8 and 0xC (including 0x10, 0x14, 0x2 and 0xFFFC) returns zero.
- R8: Writes to offsets 0x0, 0x4, 0xC and to unmapped offsets change neither led_out, nor the identification words, nor sys_rst_req.
- R9: bus_rdata is registered: it carries the addressed value in the cycle after bus_rd is high and is zero in the cycle after bus_rd is low; a read of 0x8 in the same cycle as a write to 0x8 returns the old LED value.
- R10: While rst_n is low, led_out, bus_rdata and sys_rst_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after bus_rd |
| sw_in | input | SW_W (8) | Asynchronous DIP switch levels |
| led_out | output | LED_W (8) | LED drive, 1 = lit |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted LED register shows at led_out one cycle after the bad write and in the read data one cycle after the next read of 0x8, so every LED write is followed at once by both observations. A decode fault shows as a wrong or non-zero word one cycle after reading the affected offset, and a fault in the key comparison shows as a missing or extra pulse on sys_rst_req in the cycle right after the write. Synchronizer depth faults show only as the latency of a switch change, which the bench pins down by reading before and after the expected settling cycle.

// File: rtl/board_csr_pkg.sv
package board_csr_pkg;

  // Register offsets (byte addresses inside the window)
  localparam int unsigned OFS_BUILD = 32'h0000;
  localparam int unsigned OFS_FREQ  = 32'h0004;
  localparam int unsigned OFS_LED   = 32'h0008;
  localparam int unsigned OFS_SW    = 32'h000C;
  localparam int unsigned OFS_KICK  = 32'h0010;

  // One-hot register selects produced by the decoder
  typedef struct packed {
    logic build;
    logic freq;
    logic led;
    logic sw;
    logic kick;
  } csr_sel_t;

endpackage

// File: rtl/board_csr_sync.sv
module board_csr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/board_csr_decode.sv
module board_csr_decode
  import board_csr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_t          sel
);

  always_comb begin
    sel       = '0;
    sel.build = (addr == ADDR_W'(OFS_BUILD));
    sel.freq  = (addr == ADDR_W'(OFS_FREQ));
    sel.led   = (addr == ADDR_W'(OFS_LED));
    sel.sw    = (addr == ADDR_W'(OFS_SW));
    sel.kick  = (addr == ADDR_W'(OFS_KICK));
  end

endmodule

// File: rtl/board_csr_rdmux.sv
module board_csr_rdmux
  import board_csr_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          LED_W      = 8,
  parameter int          SW_W       = 8,
  parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ     = 32'd10_000_000
) (
  input  csr_sel_t          sel,
  input  logic [LED_W-1:0]  led,
  input  logic [SW_W-1:0]   sw,
  output logic [DATA_W-1:0] value
);

  always_comb begin
    value = '0;
    unique case (1'b1)
      sel.build: value = DATA_W'(BUILD_CODE);
      sel.freq:  value = DATA_W'(CLK_HZ);
      sel.led:   value = DATA_W'(led);
      sel.sw:    value = DATA_W'(sw);
      default:   value = '0;
    endcase
  end

endmodule

// File: rtl/board_csr.sv
module board_csr
  import board_csr_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          LED_W      = 8,
  parameter int          SW_W       = 8,
  parameter int          SYNC_DEPTH = 2,
  parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
  parameter logic [31:0] CLK_HZ     = 32'd10_000_000,
  parameter logic [15:0] RESET_KEY  = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   sw_in,
  output logic [LED_W-1:0]  led_out,
  output logic              sys_rst_req
);

  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(RESET_KEY);

  csr_sel_t          sel;
  logic [SW_W-1:0]   sw_sync;
  logic [DATA_W-1:0] rd_value;

  logic [LED_W-1:0]  led_q, led_d;
  logic              led_en;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              kick_q, kick_d;

  board_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  board_csr_sync #(.W(SW_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sw_in),
    .sync_out (sw_sync)
  );

  board_csr_rdmux #(
    .DATA_W(DATA_W), .LED_W(LED_W), .SW_W(SW_W),
    .BUILD_CODE(BUILD_CODE), .CLK_HZ(CLK_HZ)
  ) u_rdmux (
    .sel   (sel),
    .led   (led_q),
    .sw    (sw_sync),
    .value (rd_value)
  );

  // Next-state logic
  always_comb begin
    led_en  = bus_wr & sel.led;
    led_d   = bus_wdata[LED_W-1:0];
    rdata_d = bus_rd ? rd_value : '0;
    kick_d  = bus_wr & sel.kick & (bus_wdata == KEY_WORD);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q   <= '0;
      rdata_q <= '0;
      kick_q  <= 1'b0;
    end else begin
      if (led_en) led_q <= led_d;
      rdata_q <= rdata_d;
      kick_q  <= kick_d;
    end
  end

  assign led_out     = led_q;
  assign bus_rdata   = rdata_q;
  assign sys_rst_req = kick_q;

  // Assertions
  assert_build_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_BUILD)) |=> bus_rdata == DATA_W'(BUILD_CODE));

  assert_freq_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_FREQ)) |=> bus_rdata == DATA_W'(CLK_HZ));

  assert_led_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_LED)) |=> led_out == $past(bus_wdata[LED_W-1:0]));

  assert_led_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFS_LED)) |=> led_out == $past(led_out));

  assert_kick_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_KICK) && bus_wdata == KEY_WORD));

  assert_kick_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_KICK) && bus_wdata == KEY_WORD) |=> sys_rst_req);

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  assert_decode_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !(sel.build || sel.freq || sel.led || sel.sw)) |=> bus_rdata == '0);

endmodule

// File: tb/board_csr_tb.sv
module board_csr_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  sw_in = '0;
  logic [7:0]  led_out;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  board_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sw_in(sw_in), .led_out(led_out), .sys_rst_req(sys_rst_req)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge with the write done.
  task automatic do_write(logic [15:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(logic [15:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    #2;
    check("R10", "led in reset", 32'(led_out), 32'h0);
    check("R10", "rdata in reset", bus_rdata, 32'h0);
    check("R10", "req in reset", 32'(sys_rst_req), 32'h0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R10", "led after reset", 32'(led_out), 32'h0);
  endtask

  task automatic t_ident;
    logic [31:0] d;
    do_read(16'h0000, d); check("R1", "build code", d, 32'h0927_2011);
    do_read(16'h0004, d); check("R2", "clock rate", d, 32'd10_000_000);
  endtask

  task automatic t_led;
    logic [31:0] d;
    do_write(16'h0008, 32'hFFFF_FFA5);
    check("R3", "led_out after write", 32'(led_out), 32'hA5);
    do_read(16'h0008, d); check("R3", "led readback", d, 32'h0000_00A5);
    do_write(16'h0008, 32'h0000_005A);
    check("R3", "led_out second write", 32'(led_out), 32'h5A);
    do_read(16'h0008, d); check("R3", "led readback 2", d, 32'h0000_005A);
  endtask

  task automatic t_switch;
    logic [31:0] d;
    sw_in = 8'hC3;
    do_read(16'h000C, d); check("R4", "switch before sync", d, 32'h0);
    @(negedge clk);
    do_read(16'h000C, d); check("R4", "switch after sync", d, 32'h0000_00C3);
    do_write(16'h000C, 32'h0000_0011);
    do_read(16'h000C, d); check("R4", "switch unchanged by write", d, 32'h0000_00C3);
    check("R8", "led after switch write", 32'(led_out), 32'h5A);
  endtask

  task automatic t_kick;
    do_write(16'h0010, 32'h0000_DEAD);
    check("R5", "pulse high after key", 32'(sys_rst_req), 32'h1);
    @(negedge clk);
    check("R5", "pulse one cycle", 32'(sys_rst_req), 32'h0);
    do_write(16'h0010, 32'h0001_DEAD);
    check("R6", "upper bits set", 32'(sys_rst_req), 32'h0);
    do_write(16'h0010, 32'h0000_BEEF);
    check("R6", "wrong key", 32'(sys_rst_req), 32'h0);
    do_write(16'h0014, 32'h0000_DEAD);
    check("R6", "key at wrong offset", 32'(sys_rst_req), 32'h0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    do_write(16'h0000, 32'h1234_5678);
    check("R8", "led after id write", 32'(led_out), 32'h5A);
    do_write(16'h0004, 32'hFFFF_FFFF);
    do_write(16'h0108, 32'h0000_00FF);
    check("R8", "led after alias write", 32'(led_out), 32'h5A);
    do_read(16'h0000, d); check("R8", "build code kept", d, 32'h0927_2011);
    do_read(16'h0004, d); check("R8", "clock rate kept", d, 32'd10_000_000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    do_read(16'h0010, d); check("R7", "read 0x10", d, 32'h0);
    do_read(16'h0014, d); check("R7", "read 0x14", d, 32'h0);
    do_read(16'h0002, d); check("R7", "read 0x2", d, 32'h0);
    do_read(16'hFFFC, d); check("R7", "read 0xFFFC", d, 32'h0);
  endtask

  task automatic t_timing;
    bus_addr = 16'h0000; bus_rd = 1'b1;
    @(negedge clk);
    check("R9", "data one cycle after rd", bus_rdata, 32'h0927_2011);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R9", "zero after rd drops", bus_rdata, 32'h0);
    bus_addr = 16'h0008; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0000_0033;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R9", "read during write gives old", bus_rdata, 32'h0000_005A);
    check("R3", "write during read lands", 32'(led_out), 32'h33);
  endtask

  initial begin
    t_reset;
    t_ident;
    t_led;
    t_switch;
    t_kick;
    t_ignored;
    t_unmapped;
    t_timing;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule